// File: doc/BRIEF.md
# Ternary Decision-Time SAR Sequencer

This block is the digital sequencer of a successive-approximation converter in which every stage makes a three-way decision instead of a two-way one. On each comparison cycle the sequencer receives the sign from the voltage comparator and a flag from a time comparator. The flag is high when the voltage comparator took longer to decide than a delay reference. A slow decision means that the residue is small, so the stage digit becomes zero and the DAC capacitor for that stage stays where it is. A fast decision gives a digit of +1 or -1 from the sign and drives that stage's capacitor one way or the other.

The ternary stages are grouped, and the stages of a group share one delay reference, which the block selects through `refSel`. A zero digit means the residue is smaller than the group's reference. The later stages of the same group would then also resolve to zero, so the sequencer skips them and moves straight to the first stage of the next group. A final two-way decision closes the conversion. The stored digits are then combined by overlapping addition into an offset-binary result. The overlap makes the result exact even when a group's delay reference is well away from its nominal value.

Units used below: the residue is counted in half-LSB steps. With the default `RES` = 10 there are nine ternary stages, numbered 0 to 8, and stage k moves the residue by 2^(9-k) half-LSB.

Top module: `tri_sar_seq`

## Requirements
- R1: After reset, `busy`, `cmpFire` and `done` are low, every bit of `dacUp` and `dacDn` is low, and `code` is 0.
- R2: `start` is accepted only while `busy` is low. A conversion then runs with `busy` high and returns to idle in the cycle in which `done` is high. A `start` pulse during a conversion changes neither the comparisons made nor the result.
- R3: In every comparison cycle `cmpFire` is high. While ternary stage k (0 to 8) is compared, `refSel` equals k div 3, so there are three groups of three stages. One final two-way comparison follows the last ternary stage.
- R4: A ternary decision with `cmpSlow`=1 gives digit 0 and drives no DAC bit. With `cmpSlow`=0 and `cmpSign`=1 (residue at or above zero) the digit is +1 and `dacUp[k]` goes high, which subtracts 2^(9-k) half-LSB from the residue. With `cmpSlow`=0 and `cmpSign`=0 the digit is -1 and `dacDn[k]` goes high, which adds the same amount. DAC bits hold until the next accepted `start`, and `dacUp[k]` and `dacDn[k]` are never high together.
- R5: After a zero digit in a group, the remaining stages of that group are skipped without a comparison cycle. A conversion therefore takes between 4 and 10 comparison cycles.
- R6: The result is 512 + Σ d_k·2^(8-k) over the ternary stages, minus 1 when the final comparison gives `cmpSign`=0, clamped to the range 0 to 1023.
- R7: `done` is a one-cycle pulse, registered one cycle after the final decision is captured, which is two cycles after the final comparison cycle. `code` changes only in a cycle in which `done` is high.
- R8: For an input code x, take the residue as 2x+1-1024 half-LSB. If the time flag means "absolute residue below T_g", the result equals x for every threshold T_g between 0 and the smallest step of group g: 128 for group 0, 16 for group 1 and 2 for group 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a conversion (taken only when idle) |
| cmpSign | input | 1 | Voltage comparator: 1 when the residue is at or above zero |
| cmpSlow | input | 1 | Time comparator: 1 when the decision was slower than the selected reference |
| cmpFire | output | 1 | Comparator clock enable for the current cycle |
| refSel | output | 2 | Delay reference (stage group) for the current comparison |
| dacUp | output | 9 | Per-stage capacitor driven to subtract its step |
| dacDn | output | 9 | Per-stage capacitor driven to add its step |
| busy | output | 1 | Conversion in progress |
| done | output | 1 | One-cycle result strobe |
| code | output | 10 | Corrected binary result |

## Verification
The checker watches, on every cycle, the rules that hold regardless of the input value. It checks that the comparator fires only inside a conversion and never more than ten times. It checks that the group selection never moves backward, that no stage drives both DAC directions, and that DAC bits set during a conversion are not released. It also checks the two-cycle spacing between the last comparison and `done`, and that `code` is held between results. Whether the digits, the skipping and the overlapping addition produce the right number can only be shown by the bench. It closes the loop through a behavioural residue model and sweeps every input code under several sets of delay-reference offsets. For each code it compares the result, the final residue and the number of comparisons against arithmetic derived from the requirements.

// File: rtl/tri_sar_pkg.sv
package tri_sar_pkg;

  // Sequencer state
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_CONV   = 2'd1,
    ST_FINISH = 2'd2
  } seqState_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic clearAll;   // new conversion: release DAC, reset digits
    logic takeDigit;  // capture ternary decision of current stage
    logic takeFinal;  // capture final two-way decision
    logic emitCode;   // register the combined result
  } dpStrobe_t;

  // Stored stage digit: middle overrides sign
  typedef struct packed {
    logic sign;
    logic middle;
  } digit_t;

endpackage

// File: rtl/tri_sar_ctrl.sv
module tri_sar_ctrl
  import tri_sar_pkg::*;
#(
  parameter int RES        = 10,
  parameter int GROUP_SIZE = 3,
  localparam int TST       = RES - 1,
  localparam int GROUPS    = (TST + GROUP_SIZE - 1) / GROUP_SIZE,
  localparam int GRP_W     = (GROUPS > 1) ? $clog2(GROUPS) : 1,
  localparam int STG_W     = $clog2(RES + 1)
)(
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic             cmpSlow,
  output dpStrobe_t        strobe,
  output logic [STG_W-1:0] stage,
  output logic             busy,
  output logic             cmpFire,
  output logic [GRP_W-1:0] refSel
);

  seqState_t        state, stateNxt;
  logic [STG_W-1:0] stageNxt;
  logic [STG_W-1:0] skipTarget;
  logic [GRP_W-1:0] grpNow;
  logic             atFinal;

  assign atFinal = (stage == STG_W'(TST));

  // Group of the current stage and first stage of the following group
  always_comb begin
    int g;
    int nextStart;
    g = int'(stage) / GROUP_SIZE;
    if (g > GROUPS - 1) g = GROUPS - 1;
    nextStart = (g + 1) * GROUP_SIZE;
    if (nextStart > TST) nextStart = TST;
    grpNow     = GRP_W'(g);
    skipTarget = STG_W'(nextStart);
  end

  always_comb begin
    stateNxt = state;
    stageNxt = stage;
    strobe   = '0;
    unique case (state)
      ST_IDLE: begin
        if (start) begin
          stateNxt        = ST_CONV;
          stageNxt        = '0;
          strobe.clearAll = 1'b1;
        end
      end
      ST_CONV: begin
        if (atFinal) begin
          strobe.takeFinal = 1'b1;
          stateNxt         = ST_FINISH;
        end else begin
          strobe.takeDigit = 1'b1;
          stageNxt         = cmpSlow ? skipTarget : stage + 1'b1;
        end
      end
      ST_FINISH: begin
        strobe.emitCode = 1'b1;
        stateNxt        = ST_IDLE;
      end
      default: stateNxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_IDLE;
      stage <= '0;
    end else begin
      state <= stateNxt;
      stage <= stageNxt;
    end
  end

  assign busy    = (state != ST_IDLE);
  assign cmpFire = (state == ST_CONV);
  assign refSel  = grpNow;

endmodule

// File: rtl/tri_sar_dp.sv
module tri_sar_dp
  import tri_sar_pkg::*;
#(
  parameter int RES        = 10,
  localparam int TST       = RES - 1,
  localparam int STG_W     = $clog2(RES + 1),
  localparam int SW        = RES + 2,
  localparam int MIDCODE   = 2 ** (RES - 1),
  localparam int MAXCODE   = 2 ** RES - 1
)(
  input  logic             clk,
  input  logic             rstN,
  input  dpStrobe_t        strobe,
  input  logic [STG_W-1:0] stage,
  input  logic             cmpSign,
  input  logic             cmpSlow,
  output logic [TST-1:0]   dacUp,
  output logic [TST-1:0]   dacDn,
  output logic [RES-1:0]   code,
  output logic             done
);

  logic signed [SW-1:0] term [TST];
  logic signed [SW-1:0] acc;
  logic                 finalBit;

  for (genvar k = 0; k < TST; k++) begin : g_stage
    localparam int WEIGHT = 2 ** (RES - 2 - k);
    digit_t dReg;
    logic   upBit, dnBit;
    logic   hit;

    assign hit = strobe.takeDigit && (stage == STG_W'(k));

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        dReg  <= '{sign: 1'b0, middle: 1'b1};
        upBit <= 1'b0;
        dnBit <= 1'b0;
      end else if (strobe.clearAll) begin
        dReg  <= '{sign: 1'b0, middle: 1'b1};
        upBit <= 1'b0;
        dnBit <= 1'b0;
      end else if (hit) begin
        dReg  <= '{sign: cmpSign, middle: cmpSlow};
        upBit <= !cmpSlow && cmpSign;
        dnBit <= !cmpSlow && !cmpSign;
      end
    end

    assign dacUp[k] = upBit;
    assign dacDn[k] = dnBit;
    assign term[k]  = dReg.middle ? '0 :
                      (dReg.sign ? SW'(WEIGHT) : -SW'(WEIGHT));
  end

  // Overlapping addition of all digits around mid-scale
  always_comb begin
    acc = SW'(MIDCODE) - (finalBit ? SW'(0) : SW'(1));
    for (int k = 0; k < TST; k++) acc = acc + term[k];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      finalBit <= 1'b0;
      code     <= '0;
      done     <= 1'b0;
    end else begin
      done <= strobe.emitCode;
      if (strobe.clearAll) finalBit <= 1'b0;
      else if (strobe.takeFinal) finalBit <= cmpSign;
      if (strobe.emitCode) begin
        if (acc < 0)                     code <= '0;
        else if (acc > SW'(MAXCODE))     code <= RES'(MAXCODE);
        else                             code <= acc[RES-1:0];
      end
    end
  end

endmodule

// File: rtl/tri_sar_seq.sv
module tri_sar_seq
  import tri_sar_pkg::*;
#(
  parameter int RES        = 10,
  parameter int GROUP_SIZE = 3,
  localparam int TST       = RES - 1,
  localparam int GROUPS    = (TST + GROUP_SIZE - 1) / GROUP_SIZE,
  localparam int GRP_W     = (GROUPS > 1) ? $clog2(GROUPS) : 1,
  localparam int STG_W     = $clog2(RES + 1)
)(
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic             cmpSign,
  input  logic             cmpSlow,
  output logic             cmpFire,
  output logic [GRP_W-1:0] refSel,
  output logic [TST-1:0]   dacUp,
  output logic [TST-1:0]   dacDn,
  output logic             busy,
  output logic             done,
  output logic [RES-1:0]   code
);

  dpStrobe_t        strobe;
  logic [STG_W-1:0] stage;

  tri_sar_ctrl #(.RES(RES), .GROUP_SIZE(GROUP_SIZE)) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .start   (start),
    .cmpSlow (cmpSlow),
    .strobe  (strobe),
    .stage   (stage),
    .busy    (busy),
    .cmpFire (cmpFire),
    .refSel  (refSel)
  );

  tri_sar_dp #(.RES(RES)) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (strobe),
    .stage   (stage),
    .cmpSign (cmpSign),
    .cmpSlow (cmpSlow),
    .dacUp   (dacUp),
    .dacDn   (dacDn),
    .code    (code),
    .done    (done)
  );

endmodule

// File: rtl/tri_sar_chk.sv
module tri_sar_chk #(
  parameter int RES        = 10,
  parameter int GROUP_SIZE = 3,
  localparam int TST       = RES - 1,
  localparam int GROUPS    = (TST + GROUP_SIZE - 1) / GROUP_SIZE,
  localparam int GRP_W     = (GROUPS > 1) ? $clog2(GROUPS) : 1,
  localparam int CW        = $clog2(RES + 2)
)(
  input logic             clk,
  input logic             rstN,
  input logic             cmpFire,
  input logic [GRP_W-1:0] refSel,
  input logic [TST-1:0]   dacUp,
  input logic [TST-1:0]   dacDn,
  input logic             busy,
  input logic             done,
  input logic [RES-1:0]   code
);

  logic [CW-1:0] fireCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)        fireCnt <= '0;
    else if (!busy)   fireCnt <= '0;
    else if (cmpFire) fireCnt <= fireCnt + 1'b1;
  end

  AST_FIRE_IN_BUSY: assert property (@(posedge clk) disable iff (!rstN) cmpFire |-> busy); // R3
  AST_FIRE_LIMIT: assert property (@(posedge clk) disable iff (!rstN) fireCnt <= CW'(RES)); // R5
  AST_REF_ORDER: assert property (@(posedge clk) disable iff (!rstN) (cmpFire && $past(cmpFire)) |-> (refSel >= $past(refSel))); // R3
  AST_DAC_EXCL: assert property (@(posedge clk) disable iff (!rstN) (dacUp & dacDn) == '0); // R4
  AST_DAC_HOLD: assert property (@(posedge clk) disable iff (!rstN) ($past(busy) && busy) |-> (((dacUp & $past(dacUp)) == $past(dacUp)) && ((dacDn & $past(dacDn)) == $past(dacDn)))); // R4
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rstN) done |-> (!busy && !cmpFire)); // R2
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rstN) done |=> !done); // R7
  AST_DONE_GAP: assert property (@(posedge clk) disable iff (!rstN) done |-> ($past(cmpFire, 2) && !$past(cmpFire))); // R7
  AST_CODE_HELD: assert property (@(posedge clk) disable iff (!rstN) (code != $past(code)) |-> done); // R7

endmodule

bind tri_sar_seq tri_sar_chk #(.RES(RES), .GROUP_SIZE(GROUP_SIZE)) u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .cmpFire (cmpFire),
  .refSel  (refSel),
  .dacUp   (dacUp),
  .dacDn   (dacDn),
  .busy    (busy),
  .done    (done),
  .code    (code)
);

// File: tb/sim_tri_sar_seq.sv
module sim_tri_sar_seq;

  localparam int RES = 10;
  localparam int GS  = 3;
  localparam int TST = RES - 1;
  localparam int NSETS = 6;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic start = 1'b0;
  logic cmpSign = 1'b0;
  logic cmpSlow = 1'b0;
  logic cmpFire, busy, done;
  logic [1:0] refSel;
  logic [TST-1:0] dacUp, dacDn;
  logic [RES-1:0] code;

  tri_sar_seq #(.RES(RES), .GROUP_SIZE(GS)) u0 (
    .clk(clk), .rstN(rstN), .start(start), .cmpSign(cmpSign), .cmpSlow(cmpSlow),
    .cmpFire(cmpFire), .refSel(refSel), .dacUp(dacUp), .dacDn(dacDn),
    .busy(busy), .done(done), .code(code)
  );

  always #2 clk = ~clk;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit finished = 1'b0;
  int thr [3];
  int thrSets [NSETS][3] = '{'{64, 8, 2}, '{128, 16, 2}, '{100, 12, 2},
                             '{20, 3, 2}, '{3, 3, 1}, '{0, 0, 0}};

  always @(posedge clk) cycles <= cycles + 1;

  initial begin
    wait (cycles >= 150000);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog (all requirements): actual %0d cycles expected fewer than 150000", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int stepOf(int k);
    return 1 << (RES - 1 - k);
  endfunction

  // Analog residue seen by the comparator, from the DAC drive
  function automatic int residue(int v);
    int r = v;
    for (int k = 0; k < TST; k++) begin
      if (dacUp[k]) r -= stepOf(k);
      if (dacDn[k]) r += stepOf(k);
    end
    return r;
  endfunction

  function automatic int skipTo(int s);
    int n = (s / GS + 1) * GS;
    return (n > TST) ? TST : n;
  endfunction

  // Expected number of comparison cycles from the requirement arithmetic
  function automatic int modelFires(int v);
    int r = v;
    int s = 0;
    int n = 0;
    while (s < TST) begin
      int t = thr[s / GS];
      n++;
      if (r < t && r > -t) s = skipTo(s);
      else begin
        r = (r >= 0) ? r - stepOf(s) : r + stepOf(s);
        s++;
      end
    end
    return n + 1;
  endfunction

  task automatic convert(input int x, input int pokeAt, output int firesOut);
    int v = 2 * x + 1 - (1 << RES);
    int expStg = 0;
    int fires = 0;
    int lastFire = -100;
    int refBad = 0;
    int r;
    bit gotDone = 1'b0;
    @(negedge clk);
    start = 1'b1;
    for (int it = 0; it < 40 && !gotDone; it++) begin
      @(negedge clk);
      start = (it == pokeAt);
      if (cmpFire) begin
        r = residue(v);
        fires++;
        lastFire = it;
        cmpSign = (r >= 0);
        if (expStg < TST) begin
          if (int'(refSel) != expStg / GS) refBad++;
          cmpSlow = (r < thr[int'(refSel)] && r > -thr[int'(refSel)]);
          expStg = cmpSlow ? skipTo(expStg) : expStg + 1;
        end else begin
          cmpSlow = 1'b0;
          expStg = TST + 1;
        end
      end
      if (done) begin
        gotDone = 1'b1;
        r = residue(v);
        check(int'(code) == x, "R8", $sformatf("code for x=%0d", x), int'(code), x);
        check(r == 1 || r == -1, "R4", $sformatf("final residue x=%0d", x), r, 1);
        check(refBad == 0, "R3", $sformatf("refSel mismatches x=%0d", x), refBad, 0);
        check(fires == modelFires(v), "R5", $sformatf("comparisons x=%0d", x), fires, modelFires(v));
        check(it - lastFire == 2, "R7", $sformatf("done spacing x=%0d", x), it - lastFire, 2);
        check(!busy, "R2", $sformatf("idle at done x=%0d", x), int'(busy), 0);
      end
    end
    start = 1'b0;
    if (!gotDone) check(1'b0, "R7", $sformatf("done missing x=%0d", x), 0, 1);
    @(negedge clk);
    check(!done, "R7", $sformatf("done pulse width x=%0d", x), int'(done), 0);
    firesOut = fires;
  endtask

  initial begin
    int f;
    int total;
    repeat (3) @(negedge clk);
    check(!busy && !cmpFire && !done, "R1", "control idle in reset", int'({busy, cmpFire, done}), 0);
    check(dacUp == '0 && dacDn == '0, "R1", "DAC released in reset", int'(dacUp | dacDn), 0);
    check(code == '0, "R1", "code in reset", int'(code), 0);
    rstN = 1'b1;
    @(negedge clk);
    check(!busy && !cmpFire && code == '0, "R1", "idle after reset", int'(busy), 0);

    // Directed: mid-scale input takes only middle digits
    thr = thrSets[0];
    convert(512, -1, f);
    check(f == 4, "R5", "comparisons at mid-scale", f, 4);
    check(dacUp == '0 && dacDn == '0, "R4", "no DAC drive on middle digits", int'(dacUp | dacDn), 0);
    repeat (4) @(negedge clk);
    check(int'(code) == 512 && !done, "R7", "code held after done", int'(code), 512);

    // Directed: full-scale input resolves every stage
    convert(1023, -1, f);
    check(f == 10, "R5", "comparisons at full scale", f, 10);
    check(dacUp == 9'h1FF && dacDn == '0, "R4", "all stages driven up", int'(dacUp), 511);
    check(int'(code) == 1023, "R6", "top code", int'(code), 1023);
    convert(0, -1, f);
    check(int'(code) == 0 && dacDn == 9'h1FF, "R6", "bottom code", int'(code), 0);

    // Start pulses during a conversion are ignored
    convert(700, 2, f);
    check(f == modelFires(2 * 700 + 1 - 1024), "R2", "comparisons with start while busy", f, modelFires(2 * 700 + 1 - 1024));
    convert(300, 0, f);
    check(int'(code) == 300, "R2", "result with start while busy", int'(code), 300);

    // Sweeps over all codes with reference offsets per group
    for (int s = 0; s < NSETS; s++) begin
      thr = thrSets[s];
      total = 0;
      for (int x = 0; x < (1 << RES); x++) begin
        convert(x, -1, f);
        total += f;
      end
      $display("reference set %0d: %0d comparisons over %0d codes", s, total, 1 << RES);
      if (s == NSETS - 1)
        check(total == 10 * (1 << RES), "R5", "no skipping with zero thresholds", total, 10 * (1 << RES));
    end

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule